// File: doc/BRIEF.md
# Clocked Serial Shift Port

This block is an eight-bit synchronous serial port built around one shift register and a three-bit bit counter. Software loads a byte, then writes a control word that picks the direction (send only, receive only, or full duplex), the shift-clock source and whether a ready handshake is used, with the start bit set. The port then moves eight bits. Outgoing data leaves most significant bit first and changes on the falling shift-clock edge. Incoming data is sampled on the rising edge and enters at the least significant end.

The shift clock comes from one of three prescaler strobes or from an external clock pin. With a strobe source, the port drives its own clock onto the pin. That clock idles high and toggles once per selected strobe. With the external source the pin is an input and is synchronised into the core clock domain. When the handshake is enabled under an external clock, an active-low ready output tells the remote master that a byte may be clocked. After the eighth rising edge the port sets a status flag and raises a one-cycle interrupt.

Top module: `sio_port`

## Requirements
- R1: After reset, mode_q reads 0x00, data_q reads 0x00, sdo and sck_o are 1, rdy_n is 1 and irq is 0.
- R2: A write with wr_addr=0 while idle updates the control word. mode_q reads {0, ready enable (bit 6), direction (bits 5:4), clock source (bits 3:2), busy (bit 1), status (bit 0)}. Writing 1 to bit 1 starts a transfer. Bit 0 cannot be written.
- R3: Clock source values 0, 1 and 2 select tap_stb[0], tap_stb[1] and tap_stb[2]. With these sources, sck_oe is 1 and sck_o idles high and toggles on each selected strobe while busy. Value 3 selects sck_i with sck_oe 0, and an edge on sck_i takes effect two to three core cycles later.
- R4: On each falling shift-clock edge, sdo presents the next bit of the loaded byte, most significant bit first. In direction 1 (receive only), sdo stays 1. sdo is 1 whenever the port is idle.
- R5: On each rising shift-clock edge, sdi enters bit 0 of the shift register. After eight rising edges, data_q holds the received byte, first bit in bit 7. In direction 0 (send only), zeros are shifted in. Directions 2 and 3 both send and receive.
- R6: rdy_n is 0 while a transfer is active only when bit 6 is 1 and the clock source is 3. It is 1 in every other case and returns to 1 when the eighth bit completes.
- R7: The eighth rising edge clears busy, sets status and gives irq for exactly one cycle. Starting a new transfer clears status.
- R8: While busy, writes to the data register (wr_addr=1) and to the control word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control word, 1 the data register |
| wr_data | input | DATA_W | Write data |
| mode_q | output | 8 | Control and status readback |
| data_q | output | DATA_W | Shift register readback |
| tap_stb | input | NUM_TAPS | One-cycle prescaler strobes |
| sck_i | input | 1 | External shift clock from the pin |
| sck_o | output | 1 | Internal shift clock to the pin |
| sck_oe | output | 1 | Clock pin output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| rdy_n | output | 1 | Active-low ready handshake |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The assertions check several properties on every cycle:
- The interrupt lasts one cycle and coincides with status set and busy clear.
- A new start always shows status cleared.
- sdo, sck_o and rdy_n sit high whenever the port is idle.
- The control fields do not move while busy.

The bit order on sdo, the byte assembled from sdi, the zero fill in send-only mode, the handshake under an external clock and the writes ignored mid-transfer are shown only by the bench's scenarios. Those scenarios use a behavioural model compared on every clock.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    DIR_TX   = 2'b00,
    DIR_RX   = 2'b01,
    DIR_DUP  = 2'b10,
    DIR_DUP2 = 2'b11
  } sio_dir_e;

  localparam logic [1:0] SRC_EXT = 2'b11;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int NUM_TAPS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy,
  input  logic [1:0]          clksel,
  input  logic [NUM_TAPS-1:0] tap_stb,
  input  logic                sck_i,
  output logic                sck_o,
  output logic                fall_ev,
  output logic                rise_ev
);
  import sio_pkg::*;

  logic       sck_q, sck_d;
  logic [2:0] sync_q;
  logic       stb_sel, ext_sel;

  assign ext_sel = (clksel == SRC_EXT);

  always_comb begin
    stb_sel = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (clksel == 2'(i)) stb_sel = tap_stb[i];
    end
  end

  always_comb begin
    fall_ev = 1'b0;
    rise_ev = 1'b0;
    sck_d   = sck_q;
    if (!busy) begin
      sck_d = 1'b1;
    end else if (ext_sel) begin
      fall_ev = sync_q[2] & ~sync_q[1];
      rise_ev = ~sync_q[2] & sync_q[1];
    end else if (stb_sel) begin
      fall_ev = sck_q;
      rise_ev = ~sck_q;
      sck_d   = ~sck_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b1;
      sync_q <= 3'b111;
    end else begin
      sck_q  <= sck_d;
      sync_q <= {sync_q[1:0], sck_i};
    end
  end

  assign sck_o = sck_q;
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              start,
  input  logic              fall_ev,
  input  logic              rise_ev,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              sdi,
  output logic [DATA_W-1:0] data_o,
  output logic              sdo,
  output logic              last_o
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sdo_q, sdo_d;

  assign last_o = rise_ev && (cnt_q == CNT_W'(DATA_W - 1));

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    sdo_d = sdo_q;
    if (load) sh_d = load_data;
    if (start) begin
      cnt_d = '0;
      sdo_d = 1'b1;
    end
    if (fall_ev) sdo_d = tx_en ? sh_q[DATA_W-1] : 1'b1;
    if (rise_ev) begin
      sh_d  = {sh_q[DATA_W-2:0], rx_en & sdi};
      cnt_d = cnt_q + 1'b1;
      if (last_o) sdo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sdo_q <= 1'b1;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      sdo_q <= sdo_d;
    end
  end

  assign data_o = sh_q;
  assign sdo    = sdo_q;
endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [6:1] cfg_in,
  input  logic       done,
  output logic       start_o,
  output logic       load_o,
  output logic       busy_o,
  output logic [1:0] clksel_o,
  output logic       tx_en,
  output logic       rx_en,
  output logic       rdy_n,
  output logic       irq,
  output logic [7:0] mode_o
);
  import sio_pkg::*;

  logic       rdy_en_q, rdy_en_d;
  sio_dir_e   dir_q, dir_d;
  logic [1:0] src_q, src_d;
  logic       busy_q, busy_d;
  logic       stat_q, stat_d;
  logic       irq_q, irq_d;
  logic       cfg_wr;

  assign cfg_wr  = wr_en & ~wr_addr & ~busy_q;
  assign start_o = cfg_wr & cfg_in[1];
  assign load_o  = wr_en & wr_addr & ~busy_q;

  always_comb begin
    rdy_en_d = rdy_en_q;
    dir_d    = dir_q;
    src_d    = src_q;
    busy_d   = busy_q;
    stat_d   = stat_q;
    irq_d    = 1'b0;
    if (cfg_wr) begin
      rdy_en_d = cfg_in[6];
      dir_d    = sio_dir_e'(cfg_in[5:4]);
      src_d    = cfg_in[3:2];
    end
    if (start_o) begin
      busy_d = 1'b1;
      stat_d = 1'b0;
    end
    if (done) begin
      busy_d = 1'b0;
      stat_d = 1'b1;
      irq_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_en_q <= 1'b0;
      dir_q    <= DIR_TX;
      src_q    <= 2'b00;
      busy_q   <= 1'b0;
      stat_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      rdy_en_q <= rdy_en_d;
      dir_q    <= dir_d;
      src_q    <= src_d;
      busy_q   <= busy_d;
      stat_q   <= stat_d;
      irq_q    <= irq_d;
    end
  end

  assign busy_o   = busy_q;
  assign clksel_o = src_q;
  assign tx_en    = (dir_q != DIR_RX);
  assign rx_en    = (dir_q != DIR_TX);
  assign rdy_n    = ~(busy_q & rdy_en_q & (src_q == SRC_EXT));
  assign irq      = irq_q;
  assign mode_o   = {1'b0, rdy_en_q, dir_q, src_q, busy_q, stat_q};
endmodule

// File: rtl/sio_port.sv
module sio_port #(
  parameter int DATA_W   = 8,
  parameter int NUM_TAPS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [7:0]          mode_q,
  output logic [DATA_W-1:0]   data_q,
  input  logic [NUM_TAPS-1:0] tap_stb,
  input  logic                sck_i,
  output logic                sck_o,
  output logic                sck_oe,
  input  logic                sdi,
  output logic                sdo,
  output logic                rdy_n,
  output logic                irq
);
  import sio_pkg::*;

  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       start, load, busy, tx_en, rx_en, done;
  logic       fall_ev, rise_ev;
  logic [1:0] clksel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  sio_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .cfg_in   (wr_data[6:1]),
    .done     (done),
    .start_o  (start),
    .load_o   (load),
    .busy_o   (busy),
    .clksel_o (clksel),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .rdy_n    (rdy_n),
    .irq      (irq),
    .mode_o   (mode_q)
  );

  sio_clkgen #(.NUM_TAPS(NUM_TAPS)) u_clkgen (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .busy    (busy),
    .clksel  (clksel),
    .tap_stb (tap_stb),
    .sck_i   (sck_i),
    .sck_o   (sck_o),
    .fall_ev (fall_ev),
    .rise_ev (rise_ev)
  );

  sio_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .load      (load),
    .load_data (wr_data),
    .start     (start),
    .fall_ev   (fall_ev),
    .rise_ev   (rise_ev),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .sdi       (sdi),
    .data_o    (data_q),
    .sdo       (sdo),
    .last_o    (done)
  );

  assign sck_oe = (clksel != SRC_EXT);
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_addr,
  input logic [7:0] mode_q,
  input logic       sdo,
  input logic       sck_o,
  input logic       rdy_n,
  input logic       irq
);
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R7
  AST_IRQ_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mode_q[0] && !mode_q[1])); // R7
  AST_START_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q[1]) |-> !mode_q[0]); // R7
  AST_SDO_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[1] |-> sdo); // R4
  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[1] |-> sck_o); // R3
  AST_RDY_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[1] |-> rdy_n); // R6
  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1] && wr_en && !wr_addr) |=> (mode_q[6:2] == $past(mode_q[6:2]))); // R8
endmodule

bind sio_port sio_port_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .mode_q  (mode_q),
  .sdo     (sdo),
  .sck_o   (sck_o),
  .rdy_n   (rdy_n),
  .irq     (irq)
);

// File: tb/sio_port_tb.sv
`timescale 1ns/100ps
module sio_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] mode_q, data_q;
  logic [2:0] tap_stb = 3'b000;
  logic       sck_i = 1'b1, sdi = 1'b0;
  logic       sck_o, sck_oe, sdo, rdy_n, irq;

  int n_chk = 0, n_fail = 0, irq_cnt = 0, tcnt = 0;
  bit cmp_en = 0;

  always #2.5 clk = ~clk;

  sio_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_q(mode_q), .data_q(data_q), .tap_stb(tap_stb), .sck_i(sck_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo), .rdy_n(rdy_n), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // prescaler strobes
  always @(negedge clk) begin
    tcnt++;
    tap_stb[0] = (tcnt % 2) == 0;
    tap_stb[1] = (tcnt % 4) == 0;
    tap_stb[2] = (tcnt % 8) == 0;
    if (irq) irq_cnt++;
  end

  // behavioural reference model
  int m_busy, m_stat, m_ren, m_dir, m_src, m_sck, m_bits, m_irq, m_sdo;
  int h1, h2, h3;
  logic [7:0] m_sh;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_stat = 0; m_ren = 0; m_dir = 0; m_src = 0; m_sck = 1;
      m_bits = 0; m_irq = 0; m_sdo = 1; m_sh = 8'h00; h1 = 1; h2 = 1; h3 = 1;
    end else begin
      int was_busy;
      bit fe, re;
      was_busy = m_busy; fe = 0; re = 0; m_irq = 0;
      if (was_busy) begin
        if (m_src == 3) begin
          fe = (h3 == 1 && h2 == 0);
          re = (h3 == 0 && h2 == 1);
        end else if (tap_stb[m_src]) begin
          if (m_sck == 1) fe = 1; else re = 1;
          m_sck = 1 - m_sck;
        end
      end else m_sck = 1;
      if (fe) m_sdo = (m_dir != 1) ? int'(m_sh[7]) : 1;
      if (re) begin
        m_sh = {m_sh[6:0], (m_dir != 0) ? sdi : 1'b0};
        m_bits++;
        if (m_bits == 8) begin m_busy = 0; m_stat = 1; m_irq = 1; m_sdo = 1; end
      end
      if (wr_en && !was_busy) begin
        if (wr_addr) m_sh = wr_data;
        else begin
          m_ren = wr_data[6]; m_dir = wr_data[5:4]; m_src = wr_data[3:2];
          if (wr_data[1]) begin m_busy = 1; m_stat = 0; m_bits = 0; m_sdo = 1; end
        end
      end
      h3 = h2; h2 = h1; h1 = sck_i;
    end
  end

  always @(negedge clk) if (cmp_en) begin
    logic [7:0] em;
    em = {1'b0, 1'(m_ren), 2'(m_dir), 2'(m_src), 1'(m_busy), 1'(m_stat)};
    chk(mode_q == em, "R2 mode_q vs model", mode_q, em);
    chk(data_q == m_sh, "R5 data_q vs model", data_q, m_sh);
    chk(sdo == 1'(m_sdo), "R4 sdo vs model", sdo, m_sdo);
    chk(sck_o == 1'(m_sck), "R3 sck_o vs model", sck_o, m_sck);
    chk(sck_oe == (m_src != 3), "R3 sck_oe vs model", sck_oe, m_src != 3);
    chk(rdy_n == !(m_busy && m_ren && m_src == 3), "R6 rdy_n vs model", rdy_n,
        !(m_busy && m_ren && m_src == 3));
    chk(irq == 1'(m_irq), "R7 irq vs model", irq, m_irq);
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic xfer_int(input logic [1:0] src, input logic [1:0] dir,
                          input logic [7:0] txb, input logic [7:0] rxb, input bit poke);
    int falls, i0;
    logic prev;
    logic [7:0] cap, exp_rx, exp_tx;
    falls = 0; prev = 1'b1; cap = 8'h00; i0 = irq_cnt;
    wr(1'b1, txb);
    wr(1'b0, {1'b0, 1'b1, dir, src, 1'b1, 1'b0});
    chk(mode_q[1] == 1'b1 && mode_q[0] == 1'b0, "R7 start sets busy, clears status", mode_q, 2);
    for (int c = 0; c < 600 && irq_cnt == i0; c++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (mode_q[1]) chk(rdy_n == 1'b1, "R6 rdy_n high with internal clock", rdy_n, 1);
      if (prev && !sck_o && falls < 8) begin
        cap = {cap[6:0], sdo};
        sdi = rxb[7 - falls];
        falls++;
        if (poke && falls == 4) begin wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'hFF; end
        if (poke && falls == 6) begin
          wr_en = 1'b1; wr_addr = 1'b0; wr_data = {1'b0, 1'b0, ~dir, ~src, 1'b1, 1'b0};
        end
      end
      prev = sck_o;
    end
    @(negedge clk);
    exp_tx = (dir == 2'b01) ? 8'hFF : txb;
    exp_rx = (dir == 2'b00) ? 8'h00 : rxb;
    chk(falls == 8, "R3 eight internal clock periods", falls, 8);
    chk(cap == exp_tx, "R4 sdo bit sequence MSB first", cap, exp_tx);
    chk(data_q == exp_rx, "R5 received byte", data_q, exp_rx);
    chk(irq_cnt - i0 == 1, "R7 one interrupt pulse", irq_cnt - i0, 1);
    chk(mode_q[1:0] == 2'b01, "R7 busy clear status set", mode_q[1:0], 1);
    if (poke) chk(mode_q[5:2] == {dir, src}, "R8 control write while busy ignored",
                  mode_q[5:2], {dir, src});
  endtask

  task automatic xfer_ext(input logic ren, input logic [1:0] dir,
                          input logic [7:0] txb, input logic [7:0] rxb);
    int i0;
    logic [7:0] cap;
    cap = 8'h00; i0 = irq_cnt;
    wr(1'b1, txb);
    wr(1'b0, {1'b0, ren, dir, 2'b11, 1'b1, 1'b0});
    chk(sck_oe == 1'b0, "R3 external source releases clock pin", sck_oe, 0);
    chk(rdy_n == !ren, "R6 rdy_n after start under external clock", rdy_n, !ren);
    for (int k = 0; k < 8; k++) begin
      sck_i = 1'b0; sdi = rxb[7 - k];
      repeat (6) @(negedge clk);
      cap = {cap[6:0], sdo};
      sck_i = 1'b1;
      repeat (6) @(negedge clk);
    end
    chk(cap == txb, "R4 sdo under external clock", cap, txb);
    chk(data_q == rxb, "R5 received byte under external clock", data_q, rxb);
    chk(rdy_n == 1'b1, "R6 rdy_n back high after eighth bit", rdy_n, 1);
    chk(irq_cnt - i0 == 1, "R7 interrupt under external clock", irq_cnt - i0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mode_q == 8'h00, "R1 mode_q reset", mode_q, 0);
    chk(data_q == 8'h00, "R1 data_q reset", data_q, 0);
    chk(sdo && sck_o && rdy_n && !irq, "R1 pins reset", {sdo, sck_o, rdy_n, irq}, 4'b1110);
    cmp_en = 1;
    // R2 plain control write, status not writable
    wr(1'b0, 8'b0110_1001);
    chk(mode_q == 8'b0110_1000, "R2 control layout, bit 0 read-only", mode_q, 8'h68);
    xfer_int(2'b00, 2'b10, 8'hA5, 8'h3C, 1'b0);
    xfer_int(2'b01, 2'b00, 8'h81, 8'hFF, 1'b0);
    xfer_int(2'b10, 2'b01, 8'h5A, 8'hC3, 1'b0);
    xfer_int(2'b00, 2'b11, 8'h96, 8'h0F, 1'b1);
    xfer_ext(1'b1, 2'b10, 8'h1E, 8'hB4);
    xfer_ext(1'b0, 2'b10, 8'hE7, 8'h42);
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule